// File: doc/BRIEF.md
# XOR Mismatch Time-Lag Search Engine

The block estimates the time offset between two one-bit signals that already sit in two byte-wide memories: a reference channel and a channel that is slid against it. For every candidate lag in a window centred on zero, the engine walks a fixed span of the reference, XORs it with the slid channel one byte per cycle, and adds the number of differing bits to a 16-bit sum. It does not store the per-lag sums. It keeps only the smallest sum seen so far and the lag that produced it. When the window is exhausted it reports a signed time difference and the winning mismatch count.

Samples are packed most significant bit first: sample k lives in byte k/8, bit 7-(k mod 8). The search bound L is eight times the configured lag-byte count, and 2L candidate lags are tried. The state machine runs S_IDLE, then S_PRIME, then S_LOAD. From S_LOAD it enters S_ACCUM, or goes straight to S_DECIDE when the span is empty. S_ACCUM moves to S_DECIDE after the last byte of the span. S_DECIDE returns to S_PRIME for the next lag, or to S_IDLE after the final lag. Each memory is read through an address output, and the addressed byte comes back on the data input one cycle later. Offsets that are not whole bytes are handled by funnel-shifting two neighbouring bytes of the slid channel, so memory is never rewritten.

Top module: `xor_lag_search`

## Requirements
- R1: After reset, done_o is 0, tau_o is 0 and min_o is 0.
- R2: With L = 8*lag_bytes and N = 8*nbytes, each lag index j from 0 to 2L-1 is scored by comparing reference sample i+L with slid sample i+j, for i from 0 to N-2L-1. min_o reports the smallest score, and the working minimum never increases during a search.
- R3: tau_o equals L minus the winning lag index, as a two's-complement value. It therefore lies in -(L-1)..L, and a slid channel with sample x equal to reference sample x+t gives tau_o = t.
- R4: The winner changes only on a strictly smaller score. On equal scores the lowest lag index is kept, so identical or uniformly mismatched channels give tau_o = L.
- R5: Samples are packed MSB first (sample k at byte k/8, bit 7-(k mod 8)). Lags that are not a multiple of 8 are resolved exactly.
- R6: The sample count and lag configuration are captured on the start pulse. A start pulse or a configuration change during a search has no effect on that search's result or timing.
- R7: done_o is high for exactly one cycle per search. tau_o and min_o change only together with done_o, and hold until the next completion.
- R8: When nbytes equals 2*lag_bytes the span is empty: every score is 0, so min_o is 0 and tau_o is L.
- R9: done_o rises exactly 2L*(W+3) clock edges after the edge that samples start_i, where W = nbytes - 2*lag_bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a search when idle |
| cfg_nbytes_i | input | ADDR_W | Sample count in bytes |
| cfg_lagbytes_i | input | LAGB_W | Search bound in bytes (L = 8x) |
| ref_addr_o | output | ADDR_W | Reference memory read address |
| ref_data_i | input | 8 | Reference byte, one cycle after its address |
| shf_addr_o | output | ADDR_W | Slid-channel memory read address |
| shf_data_i | input | 8 | Slid-channel byte, one cycle after its address |
| done_o | output | 1 | One-cycle completion pulse |
| tau_o | output | TAU_W | Signed lag result |
| min_o | output | SUM_W | Smallest mismatch count |

## Verification
The assertions assume that a search is only started with a lag-byte count of at least one and a sample count no smaller than twice the lag-byte count. They also assume that both memories hold their contents for the whole run. The bench draws its random configurations inside those limits and writes the memories only while the engine is idle. Its directed cases sit on the edges of that range: the empty span, the extreme lags ±L and the smallest bound.

// File: rtl/lag_search_pkg.sv
package lag_search_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRIME,
        S_LOAD,
        S_ACCUM,
        S_DECIDE
    } srch_state_e;

endpackage

// File: rtl/ones_count8.sv
module ones_count8 (
    input  logic [7:0] vec_i,
    output logic [3:0] cnt_o
);

    logic [1:0] pair_sum [4];
    logic [2:0] quad_sum [2];

    for (genvar p = 0; p < 4; p++) begin : g_pair
        assign pair_sum[p] = {1'b0, vec_i[2*p]} + {1'b0, vec_i[2*p+1]};
    end

    for (genvar q = 0; q < 2; q++) begin : g_quad
        assign quad_sum[q] = {1'b0, pair_sum[2*q]} + {1'b0, pair_sum[2*q+1]};
    end

    assign cnt_o = {1'b0, quad_sum[0]} + {1'b0, quad_sum[1]};

endmodule

// File: rtl/byte_align.sv
module byte_align (
    input  logic [7:0] early_i,
    input  logic [7:0] late_i,
    input  logic [2:0] shift_i,
    output logic [7:0] byte_o
);

    logic [15:0] pair_w;
    logic [7:0]  cand [8];

    assign pair_w = {early_i, late_i};

    for (genvar s = 0; s < 8; s++) begin : g_tap
        assign cand[s] = pair_w[15-s -: 8];
    end

    assign byte_o = cand[shift_i];

endmodule

// File: rtl/lag_pick.sv
module lag_pick #(
    parameter int SUM_W = 16,
    parameter int LAG_W = 7
) (
    input  logic [SUM_W-1:0] sum_i,
    input  logic [SUM_W-1:0] best_i,
    input  logic [LAG_W-1:0] best_lag_i,
    input  logic [LAG_W-1:0] cur_lag_i,
    output logic [SUM_W-1:0] best_o,
    output logic [LAG_W-1:0] best_lag_o
);

    logic better;

    assign better     = sum_i < best_i;
    assign best_o     = better ? sum_i : best_i;
    assign best_lag_o = better ? cur_lag_i : best_lag_i;

endmodule

// File: rtl/xor_lag_search.sv
module xor_lag_search
    import lag_search_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LAGB_W = 3,
    parameter int SUM_W  = 16,
    localparam int LAG_W = LAGB_W + 4,
    localparam int TAU_W = LAG_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [ADDR_W-1:0]        cfg_nbytes_i,
    input  logic [LAGB_W-1:0]        cfg_lagbytes_i,
    output logic [ADDR_W-1:0]        ref_addr_o,
    input  logic [7:0]               ref_data_i,
    output logic [ADDR_W-1:0]        shf_addr_o,
    input  logic [7:0]               shf_data_i,
    output logic                     done_o,
    output logic signed [TAU_W-1:0]  tau_o,
    output logic [SUM_W-1:0]         min_o
);

    localparam int JOFF_W = LAG_W - 3;

    srch_state_e state_q, state_d;

    logic [ADDR_W-1:0] nb_q;
    logic [LAGB_W-1:0] lb_q;
    logic [ADDR_W-1:0] win_q;
    logic [LAG_W-1:0]  j_q;
    logic [ADDR_W-1:0] b_q;
    logic [7:0]        prev_q;
    logic [SUM_W-1:0]  sum_q;
    logic [SUM_W-1:0]  min_q;
    logic [LAG_W-1:0]  lag_q;

    logic [JOFF_W-1:0] j_byte;
    logic [ADDR_W-1:0] j_base;
    logic [ADDR_W-1:0] lb_ext;
    logic [LAG_W-1:0]  j_last;
    logic [LAG_W-1:0]  bound;
    logic              span_end;
    logic [7:0]        aligned;
    logic [7:0]        diff_bits;
    logic [3:0]        diff_cnt;
    logic [SUM_W-1:0]  pick_min;
    logic [LAG_W-1:0]  pick_lag;
    logic [TAU_W-1:0]  tau_calc;

    assign j_byte   = j_q[LAG_W-1:3];
    assign j_base   = ADDR_W'(j_byte);
    assign lb_ext   = ADDR_W'(lb_q);
    assign bound    = LAG_W'({lb_q, 3'b000});
    assign j_last   = {lb_q, 4'b0000} - LAG_W'(1);
    assign span_end = (b_q == win_q - ADDR_W'(1));

    byte_align u_align (
        .early_i (prev_q),
        .late_i  (shf_data_i),
        .shift_i (j_q[2:0]),
        .byte_o  (aligned)
    );

    assign diff_bits = ref_data_i ^ aligned;

    ones_count8 u_count (
        .vec_i (diff_bits),
        .cnt_o (diff_cnt)
    );

    lag_pick #(
        .SUM_W (SUM_W),
        .LAG_W (LAG_W)
    ) u_pick (
        .sum_i      (sum_q),
        .best_i     (min_q),
        .best_lag_i (lag_q),
        .cur_lag_i  (j_q),
        .best_o     (pick_min),
        .best_lag_o (pick_lag)
    );

    assign tau_calc = TAU_W'(bound) - TAU_W'(pick_lag);

    // Read addresses: the slid channel runs one byte ahead of the reference.
    always_comb begin
        ref_addr_o = '0;
        shf_addr_o = '0;
        unique case (state_q)
            S_PRIME: begin
                shf_addr_o = j_base;
            end
            S_LOAD: begin
                shf_addr_o = j_base + ADDR_W'(1);
                ref_addr_o = lb_ext;
            end
            S_ACCUM: begin
                shf_addr_o = j_base + b_q + ADDR_W'(2);
                ref_addr_o = lb_ext + b_q + ADDR_W'(1);
            end
            default: begin
                shf_addr_o = '0;
                ref_addr_o = '0;
            end
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_PRIME;
            S_PRIME:  state_d = S_LOAD;
            S_LOAD:   state_d = (win_q == '0) ? S_DECIDE : S_ACCUM;
            S_ACCUM:  if (span_end) state_d = S_DECIDE;
            S_DECIDE: state_d = (j_q == j_last) ? S_IDLE : S_PRIME;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nb_q   <= '0;
            lb_q   <= '0;
            win_q  <= '0;
            j_q    <= '0;
            b_q    <= '0;
            prev_q <= '0;
            sum_q  <= '0;
            min_q  <= '0;
            lag_q  <= '0;
            done_o <= 1'b0;
            tau_o  <= '0;
            min_o  <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        nb_q  <= cfg_nbytes_i;
                        lb_q  <= cfg_lagbytes_i;
                        win_q <= cfg_nbytes_i - ADDR_W'({cfg_lagbytes_i, 1'b0});
                        j_q   <= '0;
                        min_q <= '1;
                        lag_q <= LAG_W'({cfg_lagbytes_i, 3'b000});
                    end
                end
                S_PRIME: begin
                    sum_q <= '0;
                end
                S_LOAD: begin
                    prev_q <= shf_data_i;
                    b_q    <= '0;
                end
                S_ACCUM: begin
                    sum_q  <= sum_q + SUM_W'(diff_cnt);
                    prev_q <= shf_data_i;
                    b_q    <= b_q + ADDR_W'(1);
                end
                S_DECIDE: begin
                    min_q <= pick_min;
                    lag_q <= pick_lag;
                    j_q   <= j_q + LAG_W'(1);
                    if (j_q == j_last) begin
                        done_o <= 1'b1;
                        tau_o  <= $signed(tau_calc);
                        min_o  <= pick_min;
                    end
                end
                default: begin
                    done_o <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/lag_search_chk.sv
module lag_search_chk
    import lag_search_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LAGB_W = 3,
    parameter int SUM_W  = 16,
    localparam int LAG_W = LAGB_W + 4,
    localparam int TAU_W = LAG_W + 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    done_o,
    input logic signed [TAU_W-1:0] tau_o,
    input logic [SUM_W-1:0]        min_o,
    input srch_state_e             state_q,
    input logic [SUM_W-1:0]        min_q,
    input logic [LAGB_W-1:0]       lb_q,
    input logic [ADDR_W-1:0]       nb_q
);

    logic signed [TAU_W-1:0] lim;
    assign lim = $signed(TAU_W'({lb_q, 3'b000}));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(tau_o) && $stable(min_o)));

    p_min_nonincr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && $past(state_q) != S_IDLE) |-> (min_q <= $past(min_q)));

    p_tau_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (tau_o <= lim && tau_o > -lim));

    p_min_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (min_o <= SUM_W'({nb_q, 3'b000})));

endmodule

bind xor_lag_search lag_search_chk #(
    .ADDR_W (ADDR_W),
    .LAGB_W (LAGB_W),
    .SUM_W  (SUM_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_o  (done_o),
    .tau_o   (tau_o),
    .min_o   (min_o),
    .state_q (state_q),
    .min_q   (min_q),
    .lb_q    (lb_q),
    .nb_q    (nb_q)
);

// File: tb/xor_lag_search_bench.sv
module xor_lag_search_bench;

    localparam int ADDR_W = 6;
    localparam int LAGB_W = 3;
    localparam int SUM_W  = 16;
    localparam int TAU_W  = LAGB_W + 5;
    localparam int DEPTH  = 1 << ADDR_W;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start = 1'b0;
    logic [ADDR_W-1:0]       nbytes = '0;
    logic [LAGB_W-1:0]       lagbytes = '0;
    logic [ADDR_W-1:0]       ref_addr, shf_addr;
    logic [7:0]              ref_data = '0, shf_data = '0;
    logic                    done;
    logic signed [TAU_W-1:0] tau;
    logic [SUM_W-1:0]        mino;

    logic [7:0] ref_mem [DEPTH];
    logic [7:0] shf_mem [DEPTH];

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        ref_data <= ref_mem[ref_addr];
        shf_data <= shf_mem[shf_addr];
    end

    xor_lag_search #(
        .ADDR_W (ADDR_W),
        .LAGB_W (LAGB_W),
        .SUM_W  (SUM_W)
    ) u_xor_lag_search (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .cfg_nbytes_i   (nbytes),
        .cfg_lagbytes_i (lagbytes),
        .ref_addr_o     (ref_addr),
        .ref_data_i     (ref_data),
        .shf_addr_o     (shf_addr),
        .shf_data_i     (shf_data),
        .done_o         (done),
        .tau_o          (tau),
        .min_o          (mino)
    );

    function automatic int rbit(int k);
        return int'(ref_mem[k >> 3][7 - (k & 7)]);
    endfunction

    function automatic int sbit(int k);
        return int'(shf_mem[k >> 3][7 - (k & 7)]);
    endfunction

    task automatic put_sbit(int k, int v);
        shf_mem[k >> 3][7 - (k & 7)] = v[0];
    endtask

    task automatic model(input int nb, input int lb, output int e_tau, output int e_min);
        int big_l = 8 * lb;
        int best = 65535;
        int win_lag = big_l;
        for (int j = 0; j < 2 * big_l; j++) begin
            int s = 0;
            for (int i = 0; i < 8 * nb - 2 * big_l; i++)
                if (rbit(i + big_l) != sbit(i + j)) s++;
            if (s < best) begin
                best = s;
                win_lag = j;
            end
        end
        e_tau = big_l - win_lag;
        e_min = best;
    endtask

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic fill_random();
        for (int a = 0; a < DEPTH; a++) begin
            ref_mem[a] = 8'($urandom);
            shf_mem[a] = 8'($urandom);
        end
    endtask

    task automatic fill_const(logic [7:0] rv, logic [7:0] sv);
        for (int a = 0; a < DEPTH; a++) begin
            ref_mem[a] = rv;
            shf_mem[a] = sv;
        end
    endtask

    // slid sample x = reference sample x+t where that exists
    task automatic make_shift(int nb, int t);
        for (int x = 0; x < 8 * nb; x++)
            if (x + t >= 0 && x + t < 8 * nb) put_sbit(x, rbit(x + t));
    endtask

    task automatic run(string req, int nb, int lb, int want_tau, bit poke);
        int e_tau, e_min, cnt;
        int w = nb - 2 * lb;
        model(nb, lb, e_tau, e_min);
        @(negedge clk);
        nbytes   = ADDR_W'(nb);
        lagbytes = LAGB_W'(lb);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        while (!done && cnt < 60000) begin
            @(negedge clk);
            if (done) break;
            cnt++;
            if (poke && cnt == 20) begin
                nbytes   = ADDR_W'(nb / 2);
                lagbytes = LAGB_W'(1);
                start    = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check(req, "watchdog", int'(done), 1);
        check("R9", "latency", cnt, 16 * lb * (w + 3));
        check(req, "tau", int'(tau), e_tau);
        check(req, "min", int'(mino), e_min);
        if (want_tau != 999) check("R3", "tau_direct", int'(tau), want_tau);
        @(negedge clk);
        check("R7", "done_pulse", int'(done), 0);
        repeat (4) @(negedge clk);
        check("R7", "tau_hold", int'(tau), e_tau);
        check("R7", "min_hold", int'(mino), e_min);
    endtask

    initial begin : wdog
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        fill_const(8'h00, 8'h00);
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", "done_rst", int'(done), 0);
        check("R1", "tau_rst", int'(tau), 0);
        check("R1", "min_rst", int'(mino), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5/R3: positive and negative sub-byte lags
        fill_random(); make_shift(16, 5);
        run("R5", 16, 3, 5, 1'b0);
        fill_random(); make_shift(16, -3);
        run("R5", 16, 3, -3, 1'b0);
        // R3: extremes of the window
        fill_random(); make_shift(20, 24);
        run("R3", 20, 3, 24, 1'b0);
        fill_random(); make_shift(20, -23);
        run("R3", 20, 3, -23, 1'b0);
        // R4: ties keep the lowest index
        fill_const(8'h00, 8'h00);
        run("R4", 12, 3, 24, 1'b0);
        fill_const(8'h00, 8'hFF);
        run("R4", 12, 3, 24, 1'b0);
        // R8: empty span
        fill_random();
        run("R8", 6, 3, 24, 1'b0);
        // R5: smallest bound
        fill_random(); make_shift(8, 3);
        run("R5", 8, 1, 3, 1'b0);
        // R6: restart and new config during a run are ignored
        fill_random(); make_shift(24, -6);
        run("R6", 24, 2, -6, 1'b1);
        // R2: random configurations and data
        for (int n = 0; n < 6; n++) begin
            int lb = 1 + int'($urandom % 7);
            int nb = 2 * lb + int'($urandom % (63 - 2 * lb + 1));
            fill_random();
            run("R2", nb, lb, 999, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule